// File: doc/BRIEF.md
# Sixteen-Bit ALU with Chained Carry

This block is the arithmetic and logic unit of a small in-order core. Each cycle in which the operation strobe is high, it takes two 16-bit operands (B and C) and a function code. It registers a 16-bit result and a new carry flag. The unit provides:

- add and subtract;
- increment and decrement;
- five bitwise functions;
- single-bit shifts and rotates.

A left shift by one has no code of its own; software issues an add of B to itself.

The carry flag is normally cleared after every operation. When the keep-carry input is high during an operation, the carry out of that operation is kept, and the operation marks the next one as chained. A chained add or subtract uses the stored carry as its carry-in in place of its usual constant. A chained logical or arithmetic right shift uses the stored carry as its incoming top bit. This lets software build add, subtract and shift operations over operands wider than one word, one word per operation. An outer counter, which is not part of this block, decides when keep-carry is raised.

Top module: `carry_alu`

## Requirements
- R1: While rst is high at a clock edge, result_o and carry_o become 0 and the following operation is not chained.
- R2: Unchained, func 0 (ADD) gives B+C and func 1 (SUB) gives B+~C+1, both modulo 2^16. The carry out is the adder carry (for SUB, 1 means no borrow).
- R3: func 2 gives B&C, 3 gives B&~C, 4 gives B|C, 5 gives B^C and 6 gives ~B. Each of these has carry out 0.
- R4: func 7 (INC) gives B+1 with carry out 1 only when B=0xFFFF. func 8 (DEC) gives B-1 with carry out 1 unless B=0. Both use a forced adder carry-in, and both ignore C and the chain state.
- R5: Unchained, func 9 (SRL) gives {0,B[15:1]}, func 10 (SRA) gives {B[15],B[15:1]}, func 11 (ROR) gives {B[0],B[15:1]} and func 12 (ROL) gives {B[14:0],B[15]}. SRL and SRA have carry out B[0]; rotates have carry out 0.
- R6: After a valid operation, carry_o equals that operation's carry out if keep_carry was high, and 0 otherwise.
- R7: A valid operation issued after a valid operation with keep_carry high is chained. A chained ADD or SUB uses carry_o as carry-in, replacing 0 for ADD and 1 for SUB.
- R8: A chained SRL or SRA takes carry_o as the incoming bit 15 of the result.
- R9: ADD with C=B acts as a left shift by one. When chained, it shifts carry_o into bit 0.
- R10: While op_valid is low, result_o, carry_o and the chain state hold.
- R11: func 13 to 15 give result 0 and carry out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe; state updates only when high |
| func | input | 4 | Function code |
| opb | input | 16 | Operand B |
| opc | input | 16 | Operand C |
| keep_carry | input | 1 | Keep this operation's carry and chain the next operation |
| result_o | output | 16 | Registered result |
| carry_o | output | 1 | Registered carry flag |

## Verification
Each function is first tried with operand pairs that produce a carry and pairs that do not. Subtract is tried with equal operands and with B smaller than C, which separates a correct borrow sense from an inverted one. INC and DEC are tried at 0xFFFF and 0 with nonzero C and a live chain, which shows whether C or the stored carry leaks into them. A four-word add, a two-word right shift and a chained B+B are then compared with wide reference values computed in the bench. Idle cycles placed between chained operations show that the carry and the chain state survive op_valid being low.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;
  typedef enum logic [3:0] {
    FN_ADD  = 4'd0,
    FN_SUB  = 4'd1,
    FN_AND  = 4'd2,
    FN_ANDN = 4'd3,
    FN_OR   = 4'd4,
    FN_XOR  = 4'd5,
    FN_NOT  = 4'd6,
    FN_INC  = 4'd7,
    FN_DEC  = 4'd8,
    FN_SRL  = 4'd9,
    FN_SRA  = 4'd10,
    FN_ROR  = 4'd11,
    FN_ROL  = 4'd12
  } alu_fn_e;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] full;
  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[W];
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import carry_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic         fill_en,
  input  logic         fill_bit,
  output logic [W-1:0] res,
  output logic         shout
);
  always_comb begin
    res   = '0;
    shout = 1'b0;
    case (fn)
      FN_AND:  res = b & c;
      FN_ANDN: res = b & ~c;
      FN_OR:   res = b | c;
      FN_XOR:  res = b ^ c;
      FN_NOT:  res = ~b;
      FN_SRL: begin
        res   = {fill_en ? fill_bit : 1'b0, b[W-1:1]};
        shout = b[0];
      end
      FN_SRA: begin
        res   = {fill_en ? fill_bit : b[W-1], b[W-1:1]};
        shout = b[0];
      end
      FN_ROR:  res = {b[0], b[W-1:1]};
      FN_ROL:  res = {b[W-2:0], b[W-1]};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/carry_alu.sv
module carry_alu
  import carry_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   func,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] opc,
  input  logic         keep_carry,
  output logic [W-1:0] result_o,
  output logic         carry_o
);
  logic         chain_q;
  logic [W-1:0] add_a, add_b, add_sum, bit_res, nxt_res;
  logic         add_ci, add_co, bit_co, nxt_co;

  alu_adder #(.W(W)) u_adder (
    .a(add_a), .b(add_b), .cin(add_ci), .sum(add_sum), .cout(add_co)
  );

  alu_bitops #(.W(W)) u_bitops (
    .fn(func), .b(opb), .c(opc), .fill_en(chain_q), .fill_bit(carry_o),
    .res(bit_res), .shout(bit_co)
  );

  always_comb begin
    add_a   = opb;
    add_b   = opc;
    add_ci  = 1'b0;
    nxt_res = bit_res;
    nxt_co  = bit_co;
    case (func)
      FN_ADD: begin
        add_ci  = chain_q & carry_o;
        nxt_res = add_sum;
        nxt_co  = add_co;
      end
      FN_SUB: begin
        add_b   = ~opc;
        add_ci  = chain_q ? carry_o : 1'b1;
        nxt_res = add_sum;
        nxt_co  = add_co;
      end
      FN_INC: begin
        add_b   = '0;
        add_ci  = 1'b1;
        nxt_res = add_sum;
        nxt_co  = add_co;
      end
      FN_DEC: begin
        // B-1 = ~(~B + 1)
        add_a   = ~opb;
        add_b   = '0;
        add_ci  = 1'b1;
        nxt_res = ~add_sum;
        nxt_co  = ~add_co;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      chain_q  <= 1'b0;
    end else if (op_valid) begin
      result_o <= nxt_res;
      carry_o  <= keep_carry & nxt_co;
      chain_q  <= keep_carry;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result_o == '0) && !carry_o);

  // R6
  carry_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !keep_carry) |=> !carry_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(result_o) && $stable(carry_o));

  // R5
  rol_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && func == FN_ROL) |=>
      result_o == {$past(opb[W-2:0]), $past(opb[W-1])});

  // R3
  not_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && func == FN_NOT) |=> result_o == ~$past(opb));
endmodule

// File: tb/carry_alu_bench.sv
`timescale 1ns/1ps
module carry_alu_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  func;
  logic [15:0] opb, opc;
  logic        keep_carry;
  logic [15:0] result_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  logic m_carry = 1'b0;
  logic m_chain = 1'b0;

  always #10 clk = ~clk;

  carry_alu u_carry_alu (
    .clk(clk), .rst(rst), .op_valid(op_valid), .func(func), .opb(opb),
    .opc(opc), .keep_carry(keep_carry), .result_o(result_o), .carry_o(carry_o)
  );

  function automatic logic [16:0] ref_op(input logic [3:0] f, input logic [15:0] b,
                                         input logic [15:0] c, input logic ch, input logic cy);
    logic [16:0] t;
    case (f)
      4'd0: t = {1'b0, b} + {1'b0, c} + {16'd0, ch & cy};
      4'd1: t = {1'b0, b} + {1'b0, ~c} + {16'd0, ch ? cy : 1'b1};
      4'd2: t = {1'b0, b & c};
      4'd3: t = {1'b0, b & ~c};
      4'd4: t = {1'b0, b | c};
      4'd5: t = {1'b0, b ^ c};
      4'd6: t = {1'b0, ~b};
      4'd7: t = {1'b0, b} + 17'd1;
      4'd8: t = {b != 16'd0, b - 16'd1};
      4'd9: t = {b[0], ch ? cy : 1'b0, b[15:1]};
      4'd10: t = {b[0], ch ? cy : b[15], b[15:1]};
      4'd11: t = {1'b0, b[0], b[15:1]};
      4'd12: t = {1'b0, b[14:0], b[15]};
      default: t = 17'd0;
    endcase
    return t;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [3:0] f, input logic [15:0] b,
                        input logic [15:0] c, input logic keep);
    logic [16:0] e;
    e = ref_op(f, b, c, m_chain, m_carry);
    op_valid = 1'b1; func = f; opb = b; opc = c; keep_carry = keep;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    m_carry = keep & e[16];
    m_chain = keep;
    check({tag, " result"}, {16'd0, result_o}, {16'd0, e[15:0]});
    check({tag, " carry"}, {31'd0, carry_o}, {31'd0, m_carry});
  endtask

  task automatic t_reset();
    rst = 1'b1; op_valid = 1'b0; func = 0; opb = 0; opc = 0; keep_carry = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R1 reset result", {16'd0, result_o}, 32'd0);
    check("R1 reset carry", {31'd0, carry_o}, 32'd0);
    rst = 1'b0;
    m_carry = 0; m_chain = 0;
    run_op("R1 first op unchained SUB", 4'd1, 16'd5, 16'd5, 1'b1);
  endtask

  task automatic t_arith();
    run_op("R2 ADD", 4'd0, 16'h1234, 16'h4321, 1'b0);
    run_op("R2 ADD wrap keep", 4'd0, 16'hFFFF, 16'h0002, 1'b1);
    run_op("R6 ADD no keep", 4'd0, 16'hFFFF, 16'h0002, 1'b0);
    run_op("R2 SUB borrow keep", 4'd1, 16'h0003, 16'h0005, 1'b1);
    run_op("R6 clear", 4'd2, 16'h0, 16'h0, 1'b0);
    run_op("R2 SUB", 4'd1, 16'h8000, 16'h0001, 1'b0);
  endtask

  task automatic t_logic();
    run_op("R3 AND", 4'd2, 16'hF0F0, 16'h3C3C, 1'b1);
    run_op("R3 ANDN", 4'd3, 16'hF0F0, 16'h3C3C, 1'b0);
    run_op("R3 OR", 4'd4, 16'hF0F0, 16'h3C3C, 1'b0);
    run_op("R3 XOR", 4'd5, 16'hF0F0, 16'h3C3C, 1'b0);
    run_op("R3 NOT", 4'd6, 16'hA5A5, 16'hFFFF, 1'b0);
  endtask

  task automatic t_incdec();
    run_op("R4 set carry", 4'd0, 16'hFFFF, 16'h0001, 1'b1);
    run_op("R4 INC max chained", 4'd7, 16'hFFFF, 16'h1234, 1'b1);
    check("R4 INC wrap", {16'd0, result_o}, 32'd0);
    run_op("R4 DEC zero chained", 4'd8, 16'h0000, 16'h5555, 1'b1);
    check("R4 DEC wrap", {16'd0, result_o}, 32'h0000FFFF);
    run_op("R4 DEC nonzero", 4'd8, 16'h0100, 16'h0000, 1'b1);
    run_op("R4 INC", 4'd7, 16'h00FF, 16'hFFFF, 1'b0);
  endtask

  task automatic t_shift();
    run_op("R5 SRL", 4'd9, 16'h8003, 16'h0, 1'b1);
    run_op("R6 clear after shift", 4'd2, 16'h0, 16'h0, 1'b0);
    run_op("R5 SRA", 4'd10, 16'h8002, 16'h0, 1'b0);
    run_op("R5 ROR", 4'd11, 16'h0001, 16'h0, 1'b0);
    run_op("R5 ROL", 4'd12, 16'h8000, 16'h0, 1'b0);
    run_op("R11 unused 13", 4'd13, 16'hFFFF, 16'hFFFF, 1'b1);
    run_op("R11 unused 15", 4'd15, 16'h1234, 16'h5678, 1'b0);
  endtask

  task automatic t_chain_add4();
    logic [63:0] a, b, s, got;
    a = 64'hFFFF_0001_FFFF_FFFF; b = 64'h0000_FFFF_0000_0001;
    s = a + b;
    for (int i = 0; i < 4; i++) begin
      run_op("R7 chained ADD word", 4'd0, a[16*i +: 16], b[16*i +: 16], i != 3);
      got[16*i +: 16] = result_o;
    end
    check("R7 four-word add low", got[31:0], s[31:0]);
    check("R7 four-word add high", got[63:32], s[63:32]);
  endtask

  task automatic t_chain_sub2();
    logic [31:0] a, b, d, got;
    a = 32'h0001_0000; b = 32'h0000_0001; d = a - b;
    run_op("R7 chained SUB low", 4'd1, a[15:0], b[15:0], 1'b1);
    got[15:0] = result_o;
    run_op("R7 chained SUB high", 4'd1, a[31:16], b[31:16], 1'b0);
    got[31:16] = result_o;
    check("R7 two-word sub", got, d);
  endtask

  task automatic t_chain_srl2();
    logic [31:0] v, got;
    v = 32'h0003_8001;
    run_op("R8 SRL high word", 4'd9, v[31:16], 16'h0, 1'b1);
    got[31:16] = result_o;
    run_op("R8 SRL low word chained", 4'd9, v[15:0], 16'h0, 1'b0);
    got[15:0] = result_o;
    check("R8 two-word SRL", got, v >> 1);
    run_op("R8 SRA high", 4'd10, 16'h8001, 16'h0, 1'b1);
    run_op("R8 SRA low chained", 4'd10, 16'h0000, 16'h0, 1'b0);
    check("R8 SRA fill", {16'd0, result_o}, 32'h00008000);
  endtask

  task automatic t_lsl();
    logic [31:0] v, got;
    v = 32'h1234_C001;
    run_op("R9 LSL low", 4'd0, v[15:0], v[15:0], 1'b1);
    got[15:0] = result_o;
    run_op("R9 LSL high chained", 4'd0, v[31:16], v[31:16], 1'b0);
    got[31:16] = result_o;
    check("R9 two-word left shift", got, v << 1);
  endtask

  task automatic t_hold();
    run_op("R10 set carry", 4'd0, 16'hFFFF, 16'h0001, 1'b1);
    opb = 16'hAAAA; opc = 16'h5555; func = 4'd4; keep_carry = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 result held", {16'd0, result_o}, 32'd0);
    check("R10 carry held", {31'd0, carry_o}, 32'd1);
    run_op("R10 chain survives idle", 4'd0, 16'h0000, 16'h0000, 1'b0);
    check("R10 chained carry-in", {16'd0, result_o}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_arith();
    t_logic();
    t_incdec();
    t_shift();
    t_chain_add4();
    t_chain_sub2();
    t_chain_srl2();
    t_lsl();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule